// File: doc/BRIEF.md
# Modified BCH Codeblock Decoder

This block checks and repairs telecommand codeblocks that arrive one bit at a time. A codeblock is 64 bits long. The first 56 bits carry the information. The next 7 bits are check bits of a (63,56) code with generator g(x) = x^7 + x^6 + x^2 + 1, and the transmitter complements them. The last bit is a filler bit. The block re-inverts the check bits and divides the 63 code bits by the generator to form a 7-bit syndrome. It then decides whether to accept or reject the codeblock and, when asked to, repairs a single flipped bit.

A codeblock starts with a strobe that comes together with its first valid bit. A bit counts only in a cycle where the valid input is high. Once the last bit has been taken, the block searches for the error position without a lookup table. It steps the residue x^d mod g(x) through all 63 code positions and compares each one with the syndrome. This search always takes the same number of cycles, so every verdict appears exactly 64 clock edges after the edge that takes the filler bit. The verdict is a one-cycle pulse that carries the 56 information bits, the accept, reject and corrected flags, and the raw filler bit. Framing logic upstream uses the filler bit to spot tail sequences.

The syndrome register, the search and the output stage are separate stages. A new codeblock can therefore stream in while the previous one is being searched.

Top module: `cbk_bch_decoder`

## Requirements
- R1: The 7 check bits are received complemented and are inverted again before the division. A codeblock with no error is accepted with corrected low, and its information output equals the transmitted 56 bits. The first received bit appears on data_out[55].
- R2: A nonzero syndrome with even weight means an even number of errors. Such a codeblock is rejected in both modes.
- R3: When corr_en is high, an odd-weight syndrome equal to x^d mod g(x) for some code degree d in 0..62 gives accept with corrected high. Degree 62 is the first bit sent and degrees 6..0 are the check bits. For d >= 7, data_out[d-7] is inverted. For d < 7, the information is passed through unchanged.
- R4: When corr_en is low, any nonzero syndrome rejects the codeblock. The information bits are then passed out as received.
- R5: When corr_en is high, an odd-weight syndrome that equals no single-error residue rejects the codeblock. The only such syndrome is x^6+x+1.
- R6: The 64th bit (the filler bit) takes no part in the syndrome. It is reported unchanged on filler_out together with the verdict.
- R7: res_valid is high for exactly one cycle. It becomes visible 64 rising edges after the edge that takes the filler bit. While res_valid is high, exactly one of accept and reject is high. All three flags are low whenever res_valid is low.
- R8: A start strobe in the middle of a codeblock abandons the partial codeblock and begins a new one. Valid bits that arrive without a start strobe after a codeblock has completed produce no result.
- R9: Cycles where bit_valid is low are skipped inside a codeblock, even if the start strobe or the data input is high during them.
- R10: Reset clears all outputs and abandons any codeblock being received or searched, so no result is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_valid | input | 1 | A serial bit is present this cycle |
| bit_in | input | 1 | Serial codeblock bit, information MSB first |
| cb_start | input | 1 | Marks the first bit of a codeblock (used only together with bit_valid) |
| corr_en | input | 1 | 1 = correct single errors, 0 = detect only; sampled with the filler bit |
| res_valid | output | 1 | One-cycle verdict strobe |
| accept | output | 1 | Codeblock accepted |
| reject | output | 1 | Codeblock rejected |
| corrected | output | 1 | A single error was located and repaired |
| data_out | output | 56 | Information bits, corrected when applicable |
| filler_out | output | 1 | Received filler bit |

## Verification
The hardest outcome to reach from the ports is the odd syndrome that matches no position. Random single or double errors never produce it, and random triple errors produce it only rarely. The stimulus table therefore injects the triple error at degrees 6, 1 and 0 directly, which makes the syndrome exactly x^6+x+1. The table also includes a triple error that the decoder miscorrects into a false accept. The expected verdicts come from a bench model that uses long division on the whole received word rather than a shift register. Gap cycles that hold the start strobe high while bit_valid is low check that the strobe is ignored when no bit is present.

// File: rtl/cbk_bch_pkg.sv
package cbk_bch_pkg;

  // The code is fixed by its generator; only the information length may shrink.
  localparam int unsigned CB_INFO_W  = 56;
  localparam int unsigned CB_PAR_W   = 7;
  // g(x) = x^7 + x^6 + x^2 + 1 without its leading term
  localparam logic [CB_PAR_W-1:0] CB_GEN_LOW = 7'h45;

  typedef struct packed {
    logic accept;
    logic reject;
    logic corrected;
  } cb_verdict_t;

  // One step of serial division: bring in the next coefficient and reduce.
  function automatic logic [CB_PAR_W-1:0] gen_div_step(
    input logic [CB_PAR_W-1:0] rem,
    input logic                coef
  );
    return {rem[CB_PAR_W-2:0], coef} ^ (rem[CB_PAR_W-1] ? CB_GEN_LOW : '0);
  endfunction

  // Multiply a residue by x modulo g(x).
  function automatic logic [CB_PAR_W-1:0] gen_times_x(
    input logic [CB_PAR_W-1:0] rem
  );
    return gen_div_step(rem, 1'b0);
  endfunction

  // (x+1) divides g(x), so syndrome weight parity equals error-count parity.
  function automatic logic syn_odd(input logic [CB_PAR_W-1:0] syn);
    return ^syn;
  endfunction

  function automatic cb_verdict_t judge(
    input logic [CB_PAR_W-1:0] syn,
    input logic                fix_mode,
    input logic                located
  );
    cb_verdict_t v;
    v = '0;
    if (syn == '0) begin
      v.accept = 1'b1;
    end else if (!fix_mode) begin
      v.reject = 1'b1;
    end else if (!syn_odd(syn)) begin
      v.reject = 1'b1;
    end else if (located) begin
      v.accept    = 1'b1;
      v.corrected = 1'b1;
    end else begin
      v.reject = 1'b1;
    end
    return v;
  endfunction

endpackage

// File: rtl/cbk_bch_intake.sv
module cbk_bch_intake
  import cbk_bch_pkg::*;
#(
  parameter int unsigned INFO_W = CB_INFO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_valid,
  input  logic                bit_in,
  input  logic                cb_start,
  output logic                frame_done,
  output logic [CB_PAR_W-1:0] syn,
  output logic [INFO_W-1:0]   info,
  output logic                filler_bit
);

  localparam int unsigned CODE_W = INFO_W + CB_PAR_W;
  localparam int unsigned BLK_W  = CODE_W + 1;
  localparam int unsigned CNT_W  = $clog2(BLK_W + 1);
  localparam logic [CNT_W-1:0] INFO_END = CNT_W'(INFO_W);
  localparam logic [CNT_W-1:0] CODE_END = CNT_W'(CODE_W);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BLK_W - 1);

  logic [CNT_W-1:0]    cnt_q;
  logic                active_q;
  logic [CB_PAR_W-1:0] syn_q;
  logic [INFO_W-1:0]   info_q;
  logic                in_info, in_par, code_bit;

  assign in_info  = cnt_q < INFO_END;
  assign in_par   = !in_info && (cnt_q < CODE_END);
  // check bits travel complemented
  assign code_bit = in_par ? ~bit_in : bit_in;

  assign frame_done = bit_valid && !cb_start && active_q && (cnt_q == LAST_IDX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      active_q <= 1'b0;
      syn_q    <= '0;
      info_q   <= '0;
    end else if (bit_valid && cb_start) begin
      cnt_q    <= CNT_W'(1);
      active_q <= 1'b1;
      syn_q    <= gen_div_step('0, bit_in);
      info_q   <= {info_q[INFO_W-2:0], bit_in};
    end else if (bit_valid && active_q) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_IDX) active_q <= 1'b0;
      if (in_info || in_par) syn_q <= gen_div_step(syn_q, code_bit);
      if (in_info) info_q <= {info_q[INFO_W-2:0], bit_in};
    end
  end

  assign syn        = syn_q;
  assign info       = info_q;
  assign filler_bit = bit_in;

endmodule

// File: rtl/cbk_bch_locator.sv
module cbk_bch_locator
  import cbk_bch_pkg::*;
#(
  parameter int unsigned INFO_W = CB_INFO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_done,
  input  logic [CB_PAR_W-1:0] syn_in,
  input  logic [INFO_W-1:0]   info_in,
  input  logic                filler_in,
  input  logic                corr_en,
  output logic                search_busy,
  output logic                search_last,
  output logic                search_done,
  output logic                found,
  output logic [$clog2(INFO_W+CB_PAR_W)-1:0] hit_deg,
  output logic [CB_PAR_W-1:0] syn_hold,
  output logic [INFO_W-1:0]   info_hold,
  output logic                filler_hold,
  output logic                mode_hold
);

  localparam int unsigned CODE_W = INFO_W + CB_PAR_W;
  localparam int unsigned POS_W  = $clog2(CODE_W);
  localparam logic [POS_W-1:0] LAST_POS = POS_W'(CODE_W - 1);

  logic                busy_q, done_q, found_q;
  logic [POS_W-1:0]    deg_q, hit_q;
  logic [CB_PAR_W-1:0] pat_q, syn_q;
  logic [INFO_W-1:0]   info_q;
  logic                filler_q, mode_q;
  logic                match;

  // pat_q walks x^deg mod g(x), starting at x^0
  assign match       = busy_q && !found_q && (pat_q == syn_q);
  assign search_last = busy_q && (deg_q == LAST_POS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      done_q   <= 1'b0;
      found_q  <= 1'b0;
      deg_q    <= '0;
      hit_q    <= '0;
      pat_q    <= '0;
      syn_q    <= '0;
      info_q   <= '0;
      filler_q <= 1'b0;
      mode_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (frame_done) begin
        busy_q   <= 1'b1;
        found_q  <= 1'b0;
        deg_q    <= '0;
        hit_q    <= '0;
        pat_q    <= CB_PAR_W'(1);
        syn_q    <= syn_in;
        info_q   <= info_in;
        filler_q <= filler_in;
        mode_q   <= corr_en;
      end else if (busy_q) begin
        if (match) begin
          found_q <= 1'b1;
          hit_q   <= deg_q;
        end
        pat_q <= gen_times_x(pat_q);
        deg_q <= deg_q + 1'b1;
        if (search_last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign search_busy = busy_q;
  assign search_done = done_q;
  assign found       = found_q;
  assign hit_deg     = hit_q;
  assign syn_hold    = syn_q;
  assign info_hold   = info_q;
  assign filler_hold = filler_q;
  assign mode_hold   = mode_q;

endmodule

// File: rtl/cbk_bch_verdict.sv
module cbk_bch_verdict
  import cbk_bch_pkg::*;
#(
  parameter int unsigned INFO_W = CB_INFO_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                search_done,
  input  logic                found,
  input  logic [$clog2(INFO_W+CB_PAR_W)-1:0] hit_deg,
  input  logic [CB_PAR_W-1:0] syn,
  input  logic [INFO_W-1:0]   info,
  input  logic                filler,
  input  logic                fix_mode,
  output logic                res_valid,
  output logic                accept,
  output logic                reject,
  output logic                corrected,
  output logic [INFO_W-1:0]   data_out,
  output logic                filler_out
);

  localparam int unsigned POS_W = $clog2(INFO_W + CB_PAR_W);

  cb_verdict_t       verdict;
  logic [INFO_W-1:0] flip;

  assign verdict = judge(syn, fix_mode, found);

  // degree d >= CB_PAR_W lands on information bit d - CB_PAR_W
  for (genvar gi = 0; gi < INFO_W; gi++) begin : g_flip
    assign flip[gi] = found && (hit_deg == POS_W'(gi + CB_PAR_W));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid  <= 1'b0;
      accept     <= 1'b0;
      reject     <= 1'b0;
      corrected  <= 1'b0;
      data_out   <= '0;
      filler_out <= 1'b0;
    end else begin
      res_valid <= search_done;
      if (search_done) begin
        accept     <= verdict.accept;
        reject     <= verdict.reject;
        corrected  <= verdict.corrected;
        data_out   <= info ^ (verdict.corrected ? flip : '0);
        filler_out <= filler;
      end else begin
        accept    <= 1'b0;
        reject    <= 1'b0;
        corrected <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/cbk_bch_decoder.sv
module cbk_bch_decoder
  import cbk_bch_pkg::*;
#(
  parameter int unsigned INFO_W = CB_INFO_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_valid,
  input  logic              bit_in,
  input  logic              cb_start,
  input  logic              corr_en,
  output logic              res_valid,
  output logic              accept,
  output logic              reject,
  output logic              corrected,
  output logic [INFO_W-1:0] data_out,
  output logic              filler_out
);

  localparam int unsigned POS_W = $clog2(INFO_W + CB_PAR_W);

  logic                frame_done;
  logic [CB_PAR_W-1:0] syn_live, syn_hold;
  logic [INFO_W-1:0]   info_live, info_hold;
  logic                filler_live, filler_hold, mode_hold;
  logic                search_busy, search_last, search_done, found;
  logic [POS_W-1:0]    hit_deg;

  cbk_bch_intake #(.INFO_W(INFO_W)) u_intake (
    .clk        (clk),
    .rst_n      (rst_n),
    .bit_valid  (bit_valid),
    .bit_in     (bit_in),
    .cb_start   (cb_start),
    .frame_done (frame_done),
    .syn        (syn_live),
    .info       (info_live),
    .filler_bit (filler_live)
  );

  cbk_bch_locator #(.INFO_W(INFO_W)) u_locator (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_done  (frame_done),
    .syn_in      (syn_live),
    .info_in     (info_live),
    .filler_in   (filler_live),
    .corr_en     (corr_en),
    .search_busy (search_busy),
    .search_last (search_last),
    .search_done (search_done),
    .found       (found),
    .hit_deg     (hit_deg),
    .syn_hold    (syn_hold),
    .info_hold   (info_hold),
    .filler_hold (filler_hold),
    .mode_hold   (mode_hold)
  );

  cbk_bch_verdict #(.INFO_W(INFO_W)) u_verdict (
    .clk         (clk),
    .rst_n       (rst_n),
    .search_done (search_done),
    .found       (found),
    .hit_deg     (hit_deg),
    .syn         (syn_hold),
    .info        (info_hold),
    .filler      (filler_hold),
    .fix_mode    (mode_hold),
    .res_valid   (res_valid),
    .accept      (accept),
    .reject      (reject),
    .corrected   (corrected),
    .data_out    (data_out),
    .filler_out  (filler_out)
  );

endmodule

// File: rtl/cbk_bch_decoder_chk.sv
module cbk_bch_decoder_chk (
  input logic clk,
  input logic rst_n,
  input logic res_valid,
  input logic accept,
  input logic reject,
  input logic corrected,
  input logic frame_done,
  input logic search_busy,
  input logic search_last,
  input logic search_done
);

  // R7: a verdict carries exactly one of accept / reject
  a_r7_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> (accept ^ reject));

  // R7: the verdict strobe lasts one cycle
  a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> !res_valid);

  // R7: flags stay low outside the strobe
  a_r7_flags_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !res_valid |-> (!accept && !reject && !corrected));

  // R3: a repair always comes with acceptance
  a_r3_corr_accepts: assert property (@(posedge clk) disable iff (!rst_n)
    corrected |-> (res_valid && accept));

  // R7: end of the search leads to the verdict on the next edge
  a_r7_search_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    search_done |=> res_valid);

  // R7: last search step is followed by the done pulse
  a_r7_last_to_done: assert property (@(posedge clk) disable iff (!rst_n)
    search_last |=> search_done);

  // R6: the filler bit closes the frame and starts the search
  a_r6_frame_starts_search: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> search_busy);

  // R8: a frame can never complete while the previous search runs
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    search_busy |-> !frame_done);

endmodule

bind cbk_bch_decoder cbk_bch_decoder_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_valid   (res_valid),
  .accept      (accept),
  .reject      (reject),
  .corrected   (corrected),
  .frame_done  (frame_done),
  .search_busy (search_busy),
  .search_last (search_last),
  .search_done (search_done)
);

// File: tb/cbk_bch_decoder_bench.sv
`timescale 1ns/1ps
module cbk_bch_decoder_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bit_valid = 1'b0;
  logic        bit_in = 1'b0;
  logic        cb_start = 1'b0;
  logic        corr_en = 1'b0;
  logic        res_valid, accept, reject, corrected, filler_out;
  logic [55:0] data_out;

  int unsigned n_cmp = 0;
  int unsigned n_bad = 0;
  bit          finished = 1'b0;

  always #2.5 clk = ~clk;

  cbk_bch_decoder u_cbk_bch_decoder (
    .clk(clk), .rst_n(rst_n), .bit_valid(bit_valid), .bit_in(bit_in),
    .cb_start(cb_start), .corr_en(corr_en), .res_valid(res_valid),
    .accept(accept), .reject(reject), .corrected(corrected),
    .data_out(data_out), .filler_out(filler_out)
  );

  typedef struct packed {
    logic [55:0] p;   // payload
    logic [62:0] e;   // error mask, bit d = degree d (bit 62 sent first)
    logic        f;   // filler
    logic        m;   // correction mode
    logic        g;   // insert gap cycles
  } vec_t;

  typedef struct packed {
    logic        acc;
    logic        rej;
    logic        cor;
    logic [55:0] data;
  } exp_t;

  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{56'h0,              63'h0,                1'b0, 1'b1, 1'b0},
    '{56'hFFFFFFFFFFFFFF, 63'h0,                1'b0, 1'b0, 1'b0},
    '{56'h0123456789ABCD, 63'h4000000000000000, 1'b0, 1'b1, 1'b0},
    '{56'h0123456789ABCD, 63'h80,               1'b0, 1'b1, 1'b0},
    '{56'h13579BDF02468A, 63'h1,                1'b0, 1'b1, 1'b0},
    '{56'h13579BDF02468A, 63'h40,               1'b0, 1'b0, 1'b0},
    '{56'hDEADBEEFCAFE12, 63'h0000000100000100, 1'b0, 1'b1, 1'b0},
    '{56'hDEADBEEFCAFE12, 63'h0000000100000100, 1'b0, 1'b0, 1'b0},
    '{56'h55AA55AA55AA55, 63'h43,               1'b0, 1'b1, 1'b0},
    '{56'h55AA55AA55AA55, 63'h83,               1'b0, 1'b1, 1'b0},
    '{56'hA5A5A5A5A5A5A5, 63'h0,                1'b1, 1'b1, 1'b0},
    '{56'h0F0F0F0F0F0F0F, 63'h0000200000000000, 1'b1, 1'b1, 1'b1},
    '{56'h0F0F0F0F0F0F0F, 63'h0000200000000000, 1'b0, 1'b0, 1'b1},
    '{56'h7766554433221F, 63'h2,                1'b0, 1'b1, 1'b1}
  };
  localparam string VTAG [NV] = '{"R1", "R1", "R3", "R3", "R3", "R4", "R2",
                                  "R2", "R5", "R5", "R6", "R9", "R4", "R9"};

  // remainder by long division over the whole word, g = 0xC5
  function automatic logic [6:0] rem_of(input logic [62:0] v);
    logic [62:0] w;
    w = v;
    for (int i = 62; i >= 7; i--) if (w[i]) w[i-:8] = w[i-:8] ^ 8'hC5;
    return w[6:0];
  endfunction

  function automatic exp_t model(input logic [55:0] p, input logic [62:0] e, input logic m);
    logic [6:0]  r, s;
    logic [62:0] rx;
    int          hit;
    exp_t        x;
    r   = rem_of({p, 7'b0});
    rx  = {p, r} ^ e;
    s   = rem_of(rx);
    hit = -1;
    for (int d = 0; d < 63; d++) if (rem_of(63'(1) << d) == s) hit = d;
    x = '0;
    x.data = rx[62:7];
    if (s == 7'd0) x.acc = 1'b1;
    else if (!m) x.rej = 1'b1;
    else if (hit < 0) x.rej = 1'b1;
    else begin
      x.acc = 1'b1;
      x.cor = 1'b1;
      if (hit >= 7) x.data[hit-7] = ~x.data[hit-7];
    end
    return x;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive_bits(input logic [63:0] tx, input logic g, input logic m);
    for (int k = 0; k < 64; k++) begin
      if (g && (k % 5 == 2)) begin
        @(negedge clk);
        bit_valid = 1'b0;
        cb_start  = 1'b1;   // must be ignored without bit_valid
        bit_in    = 1'($urandom);
      end
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = tx[63-k];
      cb_start  = (k == 0);
      corr_en   = m;
    end
    @(negedge clk);
    bit_valid = 1'b0;
    cb_start  = 1'b0;
  endtask

  task automatic send_block(input logic [55:0] p, input logic [62:0] e, input logic f,
                            input logic m, input logic g, input string tag);
    logic [6:0]  r;
    logic [63:0] tx;
    exp_t        x;
    bit          early;
    r  = rem_of({p, 7'b0});
    tx = {({p, ~r} ^ e), f};
    x  = model(p, e, m);
    drive_bits(tx, g, m);
    early = 1'b0;
    repeat (62) begin
      @(negedge clk);
      early |= res_valid;
    end
    @(negedge clk);
    early |= res_valid;
    check(!early, "R7", "strobe before edge 64", 64'(early), 64'h0);
    @(negedge clk);
    check(res_valid == 1'b1, "R7", "strobe at edge 64", 64'(res_valid), 64'h1);
    check(accept == x.acc, tag, "accept", 64'(accept), 64'(x.acc));
    check(reject == x.rej, tag, "reject", 64'(reject), 64'(x.rej));
    check(corrected == x.cor, tag, "corrected", 64'(corrected), 64'(x.cor));
    check(data_out == x.data, tag, "data_out", 64'(data_out), 64'(x.data));
    check(filler_out == f, "R6", "filler_out", 64'(filler_out), 64'(f));
    @(negedge clk);
    check(res_valid == 1'b0, "R7", "strobe width", 64'(res_valid), 64'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [55:0] p;
    logic [62:0] e;
    logic [6:0]  r;
    bit          seen;
    int          n;
    string       tag;

    repeat (3) @(negedge clk);
    check({res_valid, accept, reject, corrected, filler_out} == 5'b0, "R10",
          "flags in reset", 64'({res_valid, accept, reject, corrected, filler_out}), 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    check(data_out == 56'h0, "R10", "data after reset", 64'(data_out), 64'h0);

    // table walk
    for (int i = 0; i < NV; i++)
      send_block(VT[i].p, VT[i].e, VT[i].f, VT[i].m, VT[i].g, VTAG[i]);

    // random payloads with 0..3 injected errors
    for (int i = 0; i < 40; i++) begin
      p = 56'({$urandom, $urandom});
      n = $urandom_range(0, 3);
      e = '0;
      while ($countones(e) < n) e[$urandom_range(0, 62)] = 1'b1;
      corr_en = 1'($urandom);
      case (n)
        0: tag = "R1";
        1: tag = corr_en ? "R3" : "R4";
        2: tag = "R2";
        default: tag = "R5";
      endcase
      send_block(p, e, 1'($urandom), corr_en, 1'($urandom), tag);
    end

    // R8: partial codeblock abandoned by a fresh start strobe
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = 1'($urandom);
      cb_start  = (k == 0);
    end
    send_block(56'h00FF00FF00FF00, 63'h0000000000010000, 1'b0, 1'b1, 1'b0, "R8");

    // R8: valid bits with no start strobe after completion are ignored
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      bit_valid = 1'b1;
      bit_in    = 1'($urandom);
      cb_start  = 1'b0;
    end
    @(negedge clk);
    bit_valid = 1'b0;
    seen = 1'b0;
    repeat (80) begin
      @(negedge clk);
      seen |= res_valid;
    end
    check(!seen, "R8", "result from unstarted bits", 64'(seen), 64'h0);

    // R10: reset during the search drops the pending verdict
    p  = 56'h123456789ABCDE;
    r  = rem_of({p, 7'b0});
    drive_bits({p, ~r, 1'b0}, 1'b0, 1'b1);
    repeat (10) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    seen = 1'b0;
    repeat (70) begin
      @(negedge clk);
      seen |= res_valid;
    end
    check(!seen, "R10", "verdict after mid-search reset", 64'(seen), 64'h0);
    send_block(p, 63'h0, 1'b0, 1'b1, 1'b0, "R10");

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule